// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records when an external event happened, measured on a 16-bit free-running timer count. The count comes from outside the block. The capture input is passed through a short synchronizer. A polarity select picks which transition counts as an event: low-to-high or high-to-low. On each accepted event the block copies the count into a capture register that software can only read, and it sets a capture flag.

Software reads the 16-bit result as two bytes through a small read port, high byte first. An interlock keeps the two halves consistent. Once the high byte has been read, no new capture may overwrite the register until the low byte has been read. An event that arrives while the interlock is closed is lost. The register always holds the most recent accepted capture. It does not matter whether the flag was still set when that capture arrived.

Top module: `tcap_top`

## Requirements
- R1: When `cap_pin` changes after clock edge k, the captured value equals the `cnt_value` present at edge k, plus one, modulo 2^16. The capture register and flag take this value at edge k+3. The register reads at `rd_addr` 0 (bits 15:8) and `rd_addr` 1 (bits 7:0).
- R2: With `edge_rise`=1 only low-to-high transitions capture. With `edge_rise`=0 only high-to-low transitions capture. A transition of the other polarity leaves the register and the flag unchanged.
- R3: Every accepted capture sets `cap_flag`. A read at `rd_addr` 2 returns the flag in bit 7, with bits 6:0 zero.
- R4: A capture is accepted even while the flag is already set, and it replaces the previous value.
- R5: A read at `rd_addr` 0 closes the interlock, and a read at `rd_addr` 1 opens it. A qualifying transition that is detected while the interlock is closed does not load the register and does not set the flag. It is not applied later once the interlock opens.
- R6: Two rules apply to reads in the same cycle as a detected transition. A low-byte read in that cycle lets the capture proceed, even when the interlock is closed. A high-byte read in that cycle blocks the capture.
- R7: Reading `rd_addr` 2 while the flag is set arms a clear, and a later read of `rd_addr` 1 then clears the flag. A low-byte read without a prior arming read leaves the flag set. If the clearing read coincides with an accepted capture, the flag stays set and the arming is used up.
- R8: Synchronous reset clears the flag, the interlock and the arming. It leaves the capture register unchanged. A level change on `cap_pin` during reset causes no capture after reset is released.
- R9: `rd_data` is zero when `rd_en` is low and when `rd_addr` is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture input |
| edge_rise | input | 1 | 1: capture on rising transitions, 0: on falling |
| cnt_value | input | 16 | Free-running timer count |
| rd_en | input | 1 | Read strobe, one cycle per byte read |
| rd_addr | input | 2 | Read offset: 0 high byte, 1 low byte, 2 status |
| rd_data | output | 8 | Combinational read data |
| cap_flag | output | 1 | Capture flag |

## Verification
Suppose a transition is driven in the cycle that ends at edge k+1. The register and the flag then change at edge k+3, so they are first seen in the third sample period after the stimulus. The directed checks sample the flag one period early and one period on time to pin that latency down. A read's data is combinational in the cycle of the read, while its interlock and clear effects take hold at the following edge. The coincidence cases therefore drive the read exactly two periods after the transition. A behavioural model keeps its own history of pin and count samples, and its register state and read data are compared one nanosecond after each falling clock edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int BYTE_W   = 8;
    localparam int FLAG_BIT = 7;

    typedef enum logic [2:0] {
        RK_IDLE,
        RK_FIRST,
        RK_MID,
        RK_LAST,
        RK_STATUS,
        RK_VOID
    } rd_kind_e;

    typedef struct packed {
        logic first;   // most significant byte read: closes interlock
        logic last;    // least significant byte read: opens interlock
        logic status;  // status byte read: arms flag clear
    } rd_req_t;

    function automatic logic edge_match(input logic rise, input logic now_lvl,
                                        input logic old_lvl);
        return rise ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
    endfunction

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync
    import tcap_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] val_o
);

    logic [CNT_W-1:0]             cnt_prev_q;
    logic [STAGES-1:0]            lvl_q;
    logic [STAGES-1:0][CNT_W-1:0] snap_q;
    logic                         old_q;

    // Count snapshot travels beside the pin level, one stage per register.
    always_ff @(posedge clk) begin
        cnt_prev_q <= cnt_i;
        snap_q[0]  <= cnt_prev_q + CNT_W'(1);
        for (int s = 1; s < STAGES; s++) begin
            snap_q[s] <= snap_q[s-1];
        end
    end

    // On reset every stage takes the live level, so no edge is seen afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= {STAGES{pin_i}};
            old_q <= pin_i;
        end else begin
            lvl_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) begin
                lvl_q[s] <= lvl_q[s-1];
            end
            old_q <= lvl_q[STAGES-1];
        end
    end

    assign hit_o = edge_match(rise_i, lvl_q[STAGES-1], old_q) & ~rst;
    assign val_o = snap_q[STAGES-1];

    AST_SYNC_QUIET_AFTER_RESET: assert property (@(posedge clk) rst |=> !hit_o) else $error("edge after reset"); // R8

endmodule

// File: rtl/tcap_decode.sv
module tcap_decode
    import tcap_pkg::*;
#(
    parameter int NBYTES = 2,
    parameter int ADDR_W = 2
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_req_t           req_o
);

    rd_kind_e kind;

    always_comb begin
        if (!rd_en)                               kind = RK_IDLE;
        else if (rd_addr == ADDR_W'(0))           kind = RK_FIRST;
        else if (rd_addr == ADDR_W'(NBYTES - 1))  kind = RK_LAST;
        else if (rd_addr < ADDR_W'(NBYTES))       kind = RK_MID;
        else if (rd_addr == ADDR_W'(NBYTES))      kind = RK_STATUS;
        else                                      kind = RK_VOID;
    end

    always_comb begin
        req_o        = '0;
        req_o.first  = (kind == RK_FIRST);
        req_o.last   = (kind == RK_LAST);
        req_o.status = (kind == RK_STATUS);
    end

endmodule

// File: rtl/tcap_hold.sv
module tcap_hold
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] val_i,
    input  rd_req_t          req_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o
);

    logic [CNT_W-1:0] cap_q;
    logic             lock_q;
    logic             arm_q;
    logic             flag_q;
    logic             blocked;
    logic             take;
    logic             clr;

    assign blocked = (lock_q | req_i.first) & ~req_i.last;
    assign take    = hit_i & ~blocked & ~rst;
    assign clr     = req_i.last & arm_q & flag_q;

    // Capture register has no reset: contents survive it.
    always_ff @(posedge clk) begin
        if (take) cap_q <= val_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            arm_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (req_i.last)       lock_q <= 1'b0;
            else if (req_i.first) lock_q <= 1'b1;

            if (clr)                          arm_q <= 1'b0;
            else if (req_i.status && flag_q)  arm_q <= 1'b1;

            if (take)     flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst) take |=> cap_q == $past(val_i)) else $error("capture value"); // R1
    AST_TAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst) hit_i && !blocked |=> flag_q) else $error("flag not set"); // R3
    AST_FIRST_READ_LOCKS: assert property (@(posedge clk) disable iff (rst) req_i.first |=> lock_q) else $error("no lock"); // R5
    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst) lock_q && !req_i.last |=> $stable(cap_q)) else $error("locked load"); // R5
    AST_SAME_CYCLE_FIRST_BLOCKS: assert property (@(posedge clk) disable iff (rst) hit_i && req_i.first |=> $stable(cap_q) && flag_q == $past(flag_q)) else $error("first read let capture in"); // R6
    AST_FLAG_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (rst) !$past(rst) && $fell(flag_q) |-> $past(req_i.last && arm_q)) else $error("stray clear"); // R7

endmodule

// File: rtl/tcap_top.sv
module tcap_top
    import tcap_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STAGES = 2,
    parameter int ADDR_W = $clog2(CNT_W / 8 + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_pin,
    input  logic              edge_rise,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              cap_flag
);

    localparam int NBYTES = CNT_W / BYTE_W;

    logic                          hit;
    logic [CNT_W-1:0]              val;
    logic [CNT_W-1:0]              cap;
    rd_req_t                       req;
    logic [NBYTES-1:0][BYTE_W-1:0] lane;

    tcap_sync #(.CNT_W(CNT_W), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(cap_pin), .rise_i(edge_rise),
        .cnt_i(cnt_value), .hit_o(hit), .val_o(val)
    );

    tcap_decode #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_decode (
        .rd_en(rd_en), .rd_addr(rd_addr), .req_o(req)
    );

    tcap_hold #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst(rst), .hit_i(hit), .val_i(val), .req_i(req),
        .cap_o(cap), .flag_o(cap_flag)
    );

    // Offset 0 carries the most significant byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane[b] = cap[CNT_W-1-BYTE_W*b -: BYTE_W];
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (rd_addr == ADDR_W'(b)) rd_data = lane[b];
            end
            if (req.status) rd_data[FLAG_BIT] = cap_flag;
        end
    end

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst) !rd_en || rd_addr > ADDR_W'(NBYTES) |-> rd_data == 8'h00) else $error("bus not zero"); // R9

endmodule

// File: tb/test_tcap_top.sv
`timescale 1ns/1ps
module test_tcap_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_pin = 1'b0;
    logic        edge_rise = 1'b1;
    logic [15:0] cnt = 16'h0000;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [7:0]  rd_data;
    logic        cap_flag;

    int  compared = 0;
    int  mism = 0;
    bit  run = 0;
    int  div = 0;
    string cur_req = "R8";

    always #2 clk = ~clk;

    tcap_top i_tcap_top (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .edge_rise(edge_rise),
        .cnt_value(cnt), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .cap_flag(cap_flag)
    );

    // Behavioural reference: sample history of pin and count, plus state bits.
    logic [15:0] m_cap = 16'h0;
    bit          m_cap_ok = 0, m_flag = 0, m_lock = 0, m_arm = 0, m_live = 0;
    bit          p1, p2, p3;
    logic [15:0] c1, c2, c3;

    always @(posedge clk) begin
        bit hi, lo, st, ev, load, clr;
        hi = rd_en && rd_addr == 2'd0;
        lo = rd_en && rd_addr == 2'd1;
        st = rd_en && rd_addr == 2'd2;
        if (rst) begin
            m_flag = 0; m_lock = 0; m_arm = 0; m_live = 1;
            p1 = cap_pin; p2 = cap_pin; p3 = cap_pin;
        end else begin
            ev   = edge_rise ? (p2 && !p3) : (!p2 && p3);
            load = ev && !((m_lock || hi) && !lo);
            clr  = lo && m_arm && m_flag;
            if (load) begin m_cap = c3 + 16'd1; m_cap_ok = 1; end
            if (clr) m_arm = 0; else if (st && m_flag) m_arm = 1;
            if (load) m_flag = 1; else if (clr) m_flag = 0;
            if (lo) m_lock = 0; else if (hi) m_lock = 1;
            p3 = p2; p2 = p1; p1 = cap_pin;
        end
        c3 = c2; c2 = c1; c1 = cnt;
    end

    function automatic logic [7:0] model_rd();
        if (!rd_en) return 8'h00;
        case (rd_addr)
            2'd0:    return m_cap[15:8];
            2'd1:    return m_cap[7:0];
            2'd2:    return {m_flag, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge clk) begin
        logic [7:0] e;
        bit skip;
        #1;
        if (m_live) begin
            e = model_rd();
            skip = rd_en && rd_addr < 2'd2 && !m_cap_ok;
            compared++;
            if (cap_flag !== m_flag || (!skip && rd_data !== e)) begin
                mism++;
                $display("FAIL %s model: flag %b exp %b, data %h exp %h",
                         cur_req, cap_flag, m_flag, rd_data, e);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mism++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit en, input logic [1:0] a);
        @(negedge clk);
        if (run) begin
            div = div + 1;
            if (div == 4) begin div = 0; cnt = cnt + 16'd1; end
        end
        rd_en = en;
        rd_addr = a;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(0, 2'd0);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        cyc(1, a);
        d = rd_data;
    endtask

    task automatic edge_cyc(input logic v);
        cyc(0, 2'd0);
        cap_pin = v;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mism++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R8 reset state
        cur_req = "R8";
        chk("R8 flag after reset", {15'b0, cap_flag}, 16'h0);
        rd(2'd2, d); chk("R8 status after reset", {8'h0, d}, 16'h0000);

        // R1 value and latency
        cur_req = "R1";
        cnt = 16'h1233; idle(1);
        edge_cyc(1'b1);
        idle(2); chk("R1 flag one period early", {15'b0, cap_flag}, 16'h0);
        idle(1); chk("R1 flag on time", {15'b0, cap_flag}, 16'h1);
        rd(2'd0, d); chk("R1 high byte", {8'h0, d}, 16'h0012);
        rd(2'd1, d); chk("R1 low byte", {8'h0, d}, 16'h0034);

        // R7 clear needs arming; R3 status format
        cur_req = "R7";
        rd(2'd1, d); idle(1);
        chk("R7 unarmed low read keeps flag", {15'b0, cap_flag}, 16'h1);
        rd(2'd2, d); chk("R3 status byte", {8'h0, d}, 16'h0080);
        rd(2'd1, d); idle(1);
        chk("R7 armed clear", {15'b0, cap_flag}, 16'h0);

        // R2 polarity
        cur_req = "R2";
        edge_cyc(1'b0); idle(4);
        chk("R2 falling ignored when rising selected", {15'b0, cap_flag}, 16'h0);
        rd(2'd0, d); chk("R2 high unchanged", {8'h0, d}, 16'h0012);
        rd(2'd1, d); chk("R2 low unchanged", {8'h0, d}, 16'h0034);
        edge_rise = 1'b0; cnt = 16'h0500; idle(1);
        edge_cyc(1'b1); idle(4);
        chk("R2 rising ignored when falling selected", {15'b0, cap_flag}, 16'h0);
        edge_cyc(1'b0); idle(4);
        chk("R2 falling captured", {15'b0, cap_flag}, 16'h1);
        rd(2'd0, d); chk("R2 high", {8'h0, d}, 16'h0005);
        rd(2'd1, d); chk("R2 low", {8'h0, d}, 16'h0001);

        // R4 overwrite while flag set, with count wrap
        cur_req = "R4";
        edge_rise = 1'b1; cnt = 16'hFFFF; idle(1);
        edge_cyc(1'b1); idle(4);
        rd(2'd0, d); chk("R4 high after wrap", {8'h0, d}, 16'h0000);
        rd(2'd1, d); chk("R4 low after wrap", {8'h0, d}, 16'h0000);
        chk("R4 flag still set", {15'b0, cap_flag}, 16'h1);

        // R5 interlock discards and does not replay
        cur_req = "R5";
        rd(2'd0, d);
        cnt = 16'h2222;
        edge_cyc(1'b0); idle(2);
        edge_cyc(1'b1); idle(4);
        rd(2'd1, d); chk("R5 low while locked keeps old", {8'h0, d}, 16'h0000);
        idle(6);
        rd(2'd0, d); chk("R5 no replay high", {8'h0, d}, 16'h0000);
        rd(2'd1, d); chk("R5 no replay low", {8'h0, d}, 16'h0000);

        // R6 low read in detection cycle lets capture through
        cur_req = "R6";
        rd(2'd0, d);
        cnt = 16'h3456;
        edge_cyc(1'b0); idle(2);
        edge_cyc(1'b1); idle(1);
        rd(2'd1, d); chk("R6 coincident low read returns old", {8'h0, d}, 16'h0000);
        idle(3);
        rd(2'd0, d); chk("R6 low read passes capture high", {8'h0, d}, 16'h0034);
        rd(2'd1, d); chk("R6 low read passes capture low", {8'h0, d}, 16'h0057);

        // R6 high read in detection cycle blocks
        cnt = 16'h4000;
        edge_cyc(1'b0); idle(3);
        edge_cyc(1'b1); idle(1);
        rd(2'd0, d); idle(3);
        rd(2'd1, d); chk("R6 high read blocks low", {8'h0, d}, 16'h0057);
        idle(3);
        rd(2'd0, d); chk("R6 high read blocks high", {8'h0, d}, 16'h0034);
        rd(2'd1, d);

        // R7 set wins over clear
        cur_req = "R7";
        rd(2'd2, d); chk("R7 status before clear", {8'h0, d}, 16'h0080);
        cnt = 16'h0777;
        edge_cyc(1'b0); idle(3);
        edge_cyc(1'b1); idle(1);
        rd(2'd1, d); idle(1);
        chk("R7 capture beats clear", {15'b0, cap_flag}, 16'h1);
        rd(2'd1, d); chk("R7 captured low", {8'h0, d}, 16'h0078);
        idle(1);
        chk("R7 arming used up", {15'b0, cap_flag}, 16'h1);

        // R9 unused offset and idle bus
        cur_req = "R9";
        rd(2'd3, d); chk("R9 offset 3", {8'h0, d}, 16'h0000);
        idle(1); chk("R9 idle bus", {8'h0, rd_data}, 16'h0000);

        // R8 reset clears interlock and flag, pin change during reset ignored
        cur_req = "R8";
        edge_rise = 1'b0;
        rd(2'd0, d);
        rst = 1'b1; idle(1);
        cap_pin = 1'b0; idle(2);
        rst = 1'b0; idle(5);
        chk("R8 no capture from reset-time level change", {15'b0, cap_flag}, 16'h0);
        rd(2'd2, d); chk("R8 status cleared", {8'h0, d}, 16'h0000);
        cnt = 16'h0ABC;
        edge_cyc(1'b1); idle(3);
        edge_cyc(1'b0); idle(4);
        chk("R8 interlock cleared by reset", {15'b0, cap_flag}, 16'h1);
        rst = 1'b1; idle(3);
        rst = 1'b0; idle(3);
        rd(2'd0, d); chk("R8 high kept through reset", {8'h0, d}, 16'h000A);
        rd(2'd1, d); chk("R8 low kept through reset", {8'h0, d}, 16'h00BD);

        // Running count, random traffic against the model
        cur_req = "R1 R5 random";
        run = 1;
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 4) == 0, 2'($urandom % 4));
            if (($urandom % 6) == 0) cap_pin = ~cap_pin;
            if (($urandom % 300) == 0) edge_rise = ~edge_rise;
        end
        idle(4);

        summary();
        $finish;
    end

endmodule